// File: doc/BRIEF.md
# Operand-Snooping Reservation Station

This block is one reservation station that sits in front of a single functional unit in an out-of-order core. The issue logic hands it one instruction: an opcode and two source operands. Each operand arrives either as a finished value or as the tag of the station that will produce that value. The station keeps the instruction until both sources hold values. It then offers the instruction to the functional unit through a valid/ready handshake.

While a source is still waiting, the station compares the waiting tag with every result broadcast on the shared result bus. On a match it captures the broadcast value, so hazard tracking is done locally in each station and no central scoreboard is needed. A busy output tells the issue logic to stall. The station frees itself in the cycle the unit accepts the operation. Each dispatched instruction carries the station's own fixed identifier, which becomes the destination tag of the result. A synchronous flush drops whatever instruction is held.

Top module: `rs_station`

## Requirements
- R1: After reset, `busy_o` is 0 and `fu_valid_o` is 0.
- R2: When `iss_valid_i` is 1, `busy_o` is 0 and `flush_i` is 0, the instruction is captured at that clock edge and `busy_o` reads 1 from the next cycle. `fu_dest_tag_o` always equals the parameter `STATION_ID`, which is 5 by default.
- R3: An issue presented while `busy_o` is 1 is ignored. The opcode and the operands already held stay unchanged.
- R4: `fu_valid_o` is 1 only while an instruction is held and both of its sources hold values. Each accepted dispatch presents the opcode and the two source values of the issued instruction.
- R5: When a source is waiting and `cdb_valid_i` is 1 with `cdb_tag_i` equal to that source's tag, the source takes `cdb_data_i` at that edge. If the other source already holds a value, `fu_valid_o` rises in the next cycle.
- R6: A broadcast with a different tag, or a broadcast with `cdb_valid_i` at 0, leaves a waiting source waiting.
- R7: A source that already holds a value keeps that value when a broadcast arrives carrying its stale tag field.
- R8: A waiting source whose tag matches a broadcast in the same cycle as its issue is captured at that issue edge.
- R9: While `fu_valid_o` is 1 and `fu_ready_i` is 0, the offer and its payload are held steady. The cycle after `fu_valid_o` and `fu_ready_i` are both 1, `busy_o` reads 0.
- R10: `flush_i` at 1 makes `busy_o` read 0 in the next cycle and takes priority over a simultaneous issue. A later broadcast matching the dropped instruction's tag produces no dispatch.
- R11: When both sources wait on the same tag, a single matching broadcast fills both of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous drop of the held instruction |
| iss_valid_i | input | 1 | Issue request |
| iss_op_i | input | OP_W | Opcode to hold |
| iss_src0_ready_i | input | 1 | Source 0 carries a value (1) or a tag (0) |
| iss_src0_tag_i | input | TAG_W | Producer tag of source 0 |
| iss_src0_data_i | input | DATA_W | Value of source 0 |
| iss_src1_ready_i | input | 1 | Source 1 carries a value (1) or a tag (0) |
| iss_src1_tag_i | input | TAG_W | Producer tag of source 1 |
| iss_src1_data_i | input | DATA_W | Value of source 1 |
| busy_o | output | 1 | Station occupied; issue must stall |
| cdb_valid_i | input | 1 | Result broadcast present |
| cdb_tag_i | input | TAG_W | Tag of the broadcasting producer |
| cdb_data_i | input | DATA_W | Broadcast result value |
| fu_valid_o | output | 1 | Operation offered to the unit |
| fu_ready_i | input | 1 | Unit accepts the offer |
| fu_op_o | output | OP_W | Offered opcode |
| fu_src0_o | output | DATA_W | Offered source 0 value |
| fu_src1_o | output | DATA_W | Offered source 1 value |
| fu_dest_tag_o | output | TAG_W | Destination tag (station identifier) |

## Verification
A corrupted source-ready bit has two possible symptoms at the ports. Either `fu_valid_o` rises before the producing broadcast arrives, or it never rises at all and `busy_o` stays high indefinitely. A wrong captured value shows up as a bad payload at the very next handshake. A stuck occupancy state shows up as `busy_o` staying high one cycle after an accepted dispatch or a flush. It can also show up as a second issue overwriting the held opcode. Every one of these symptoms appears at the ports within one or two cycles of the triggering event, which is where the scoreboard compares.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int NUM_SRC = 2;
  typedef enum logic {ST_FREE = 1'b0, ST_HELD = 1'b1} rs_state_e;
endpackage

// File: rtl/rs_src_slot.sv
module rs_src_slot #(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              ld_ready_i,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] data_o
);
  logic              rdy_q, rdy_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              hit_ld, hit_hold, en;

  always_comb begin
    hit_ld   = cdb_valid_i && (cdb_tag_i == ld_tag_i);
    hit_hold = cdb_valid_i && !rdy_q && (cdb_tag_i == tag_q);
    en       = load_i || hit_hold;
    rdy_d    = rdy_q;
    tag_d    = tag_q;
    data_d   = data_q;
    if (load_i) begin
      tag_d  = ld_tag_i;
      rdy_d  = ld_ready_i || hit_ld;
      data_d = (!ld_ready_i && hit_ld) ? cdb_data_i : ld_data_i;
    end else if (hit_hold) begin
      rdy_d  = 1'b1;
      data_d = cdb_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      tag_q  <= '0;
      data_q <= '0;
    end else if (en) begin
      rdy_q  <= rdy_d;
      tag_q  <= tag_d;
      data_q <= data_d;
    end
  end

  assign ready_o = rdy_q;
  assign data_o  = data_q;

  // R7: a filled source is never overwritten by a broadcast
  a_r7_value_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o && !load_i |=> ready_o && $stable(data_o));

  // R5: a matching broadcast fills a waiting source
  a_r5_snoop_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o && !load_i && cdb_valid_i && (cdb_tag_i == tag_q)
    |=> ready_o && (data_o == $past(cdb_data_i)));
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic iss_valid_i,
  input  logic srcs_ready_i,
  input  logic fu_ready_i,
  output logic busy_o,
  output logic load_o,
  output logic fu_valid_o
);
  rs_state_e state_q, state_d;

  always_comb begin
    load_o     = iss_valid_i && (state_q == ST_FREE) && !flush_i;
    fu_valid_o = (state_q == ST_HELD) && srcs_ready_i;
    state_d    = state_q;
    if (flush_i)
      state_d = ST_FREE;
    else if (load_o)
      state_d = ST_HELD;
    else if (fu_valid_o && fu_ready_i)
      state_d = ST_FREE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FREE;
    else        state_q <= state_d;
  end

  assign busy_o = (state_q == ST_HELD);

  // R10: flush empties the station
  a_r10_flush_frees: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !busy_o);

  // R9: accepted dispatch frees the station
  a_r9_accept_frees: assert property (@(posedge clk) disable iff (!rst_n)
    fu_valid_o && fu_ready_i |=> !busy_o);

  // R3: an occupied station stays occupied until accept or flush
  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !(fu_valid_o && fu_ready_i) && !flush_i |=> busy_o);

  // R2: a free station takes an issue
  a_r2_issue_taken: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid_i && !busy_o && !flush_i |=> busy_o);
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
#(
  parameter int OP_W       = 4,
  parameter int TAG_W      = 3,
  parameter int DATA_W     = 32,
  parameter int STATION_ID = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              iss_valid_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic              iss_src0_ready_i,
  input  logic [TAG_W-1:0]  iss_src0_tag_i,
  input  logic [DATA_W-1:0] iss_src0_data_i,
  input  logic              iss_src1_ready_i,
  input  logic [TAG_W-1:0]  iss_src1_tag_i,
  input  logic [DATA_W-1:0] iss_src1_data_i,
  output logic              busy_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic              fu_valid_o,
  input  logic              fu_ready_i,
  output logic [OP_W-1:0]   fu_op_o,
  output logic [DATA_W-1:0] fu_src0_o,
  output logic [DATA_W-1:0] fu_src1_o,
  output logic [TAG_W-1:0]  fu_dest_tag_o
);
  localparam logic [TAG_W-1:0] OWN_TAG = TAG_W'(STATION_ID);

  logic                        load;
  logic [NUM_SRC-1:0]          ld_rdy;
  logic [NUM_SRC-1:0]          src_rdy;
  logic [NUM_SRC-1:0][TAG_W-1:0]  ld_tag;
  logic [NUM_SRC-1:0][DATA_W-1:0] ld_data;
  logic [NUM_SRC-1:0][DATA_W-1:0] src_data;
  logic [OP_W-1:0]             op_q;

  assign ld_rdy  = {iss_src1_ready_i, iss_src0_ready_i};
  assign ld_tag  = {iss_src1_tag_i, iss_src0_tag_i};
  assign ld_data = {iss_src1_data_i, iss_src0_data_i};

  rs_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .iss_valid_i  (iss_valid_i),
    .srcs_ready_i (&src_rdy),
    .fu_ready_i   (fu_ready_i),
    .busy_o       (busy_o),
    .load_o       (load),
    .fu_valid_o   (fu_valid_o)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    rs_src_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load),
      .ld_ready_i  (ld_rdy[g]),
      .ld_tag_i    (ld_tag[g]),
      .ld_data_i   (ld_data[g]),
      .cdb_valid_i (cdb_valid_i),
      .cdb_tag_i   (cdb_tag_i),
      .cdb_data_i  (cdb_data_i),
      .ready_o     (src_rdy[g]),
      .data_o      (src_data[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    op_q <= '0;
    else if (load) op_q <= iss_op_i;
  end

  assign fu_op_o       = op_q;
  assign fu_src0_o     = src_data[0];
  assign fu_src1_o     = src_data[1];
  assign fu_dest_tag_o = OWN_TAG;

  // R9: an unaccepted offer is held with its payload
  a_r9_offer_stable: assert property (@(posedge clk) disable iff (!rst_n)
    fu_valid_o && !fu_ready_i && !flush_i
    |=> fu_valid_o && $stable(fu_op_o) && $stable(fu_src0_o) && $stable(fu_src1_o));

  // R4: an offer requires an occupied station
  a_r4_offer_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fu_valid_o |-> busy_o);
endmodule

// File: tb/rs_station_tb_top.sv
module rs_station_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i, iss_valid_i;
  logic [3:0]  iss_op_i;
  logic        iss_src0_ready_i, iss_src1_ready_i;
  logic [2:0]  iss_src0_tag_i, iss_src1_tag_i;
  logic [31:0] iss_src0_data_i, iss_src1_data_i;
  logic        busy_o, cdb_valid_i, fu_valid_o, fu_ready_i;
  logic [2:0]  cdb_tag_i, fu_dest_tag_o;
  logic [31:0] cdb_data_i, fu_src0_o, fu_src1_o;
  logic [3:0]  fu_op_o;

  typedef struct packed { logic [3:0] op; logic [31:0] a; logic [31:0] b; } exp_t;
  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rs_station dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic issue(input logic [3:0] op, input logic r0, input logic [2:0] t0, input logic [31:0] d0,
                       input logic r1, input logic [2:0] t1, input logic [31:0] d1);
    iss_valid_i = 1'b1; iss_op_i = op;
    iss_src0_ready_i = r0; iss_src0_tag_i = t0; iss_src0_data_i = d0;
    iss_src1_ready_i = r1; iss_src1_tag_i = t1; iss_src1_data_i = d1;
    step();
    iss_valid_i = 1'b0;
  endtask

  task automatic bcast(input logic [2:0] t, input logic [31:0] d);
    cdb_valid_i = 1'b1; cdb_tag_i = t; cdb_data_i = d;
    step();
    cdb_valid_i = 1'b0;
  endtask

  task automatic accept();
    fu_ready_i = 1'b1;
    step();
    fu_ready_i = 1'b0;
  endtask

  // scoreboard monitor: compares each handshake against the queue
  always @(negedge clk) begin
    if (rst_n && fu_valid_o && fu_ready_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected dispatch", {60'h0, fu_op_o}, 64'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(fu_op_o == e.op && fu_src0_o == e.a && fu_src1_o == e.b, "R4 dispatch payload",
            {fu_src0_o, fu_src1_o}, {e.a, e.b});
      end
    end
  end

  initial begin
    #400000;
    chk(1'b0, "watchdog", 64'h0, 64'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush_i = 1'b0; iss_valid_i = 1'b0; iss_op_i = '0;
    iss_src0_ready_i = 1'b0; iss_src0_tag_i = '0; iss_src0_data_i = '0;
    iss_src1_ready_i = 1'b0; iss_src1_tag_i = '0; iss_src1_data_i = '0;
    cdb_valid_i = 1'b0; cdb_tag_i = '0; cdb_data_i = '0; fu_ready_i = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    chk(busy_o == 1'b0, "R1 busy after reset", {63'h0, busy_o}, 64'h0);
    chk(fu_valid_o == 1'b0, "R1 valid after reset", {63'h0, fu_valid_o}, 64'h0);

    // both sources ready at issue
    exp_q.push_back('{op: 4'd1, a: 32'd10, b: 32'd20});
    issue(4'd1, 1'b1, 3'd0, 32'd10, 1'b1, 3'd0, 32'd20);
    chk(busy_o == 1'b1, "R2 busy after issue", {63'h0, busy_o}, 64'h1);
    chk(fu_dest_tag_o == 3'd5, "R2 destination tag", {61'h0, fu_dest_tag_o}, 64'h5);
    chk(fu_valid_o == 1'b1, "R4 offer with ready sources", {63'h0, fu_valid_o}, 64'h1);
    issue(4'd7, 1'b1, 3'd0, 32'd99, 1'b1, 3'd0, 32'd99);
    chk(fu_op_o == 4'd1 && fu_src0_o == 32'd10, "R3 issue while busy ignored",
        {28'h0, fu_op_o, fu_src0_o}, {28'h0, 4'd1, 32'd10});
    step();
    chk(fu_valid_o == 1'b1 && fu_src1_o == 32'd20, "R9 offer held", {32'h0, fu_src1_o}, 64'd20);
    accept();
    chk(busy_o == 1'b0 && fu_valid_o == 1'b0, "R9 free after accept", {63'h0, busy_o}, 64'h0);

    // source 0 waits on tag 2; source 1 ready with stale tag 2
    exp_q.push_back('{op: 4'd2, a: 32'd33, b: 32'd5});
    issue(4'd2, 1'b0, 3'd2, 32'd0, 1'b1, 3'd2, 32'd5);
    chk(fu_valid_o == 1'b0, "R4 no offer while waiting", {63'h0, fu_valid_o}, 64'h0);
    bcast(3'd3, 32'd77);
    chk(fu_valid_o == 1'b0, "R6 other tag ignored", {63'h0, fu_valid_o}, 64'h0);
    cdb_tag_i = 3'd2; cdb_data_i = 32'd88;
    step();
    chk(fu_valid_o == 1'b0, "R6 invalid bus ignored", {63'h0, fu_valid_o}, 64'h0);
    bcast(3'd2, 32'd33);
    chk(fu_valid_o == 1'b1 && fu_src0_o == 32'd33, "R5 snoop fill", {32'h0, fu_src0_o}, 64'd33);
    chk(fu_src1_o == 32'd5, "R7 ready source kept", {32'h0, fu_src1_o}, 64'd5);
    accept();

    // broadcast in the same cycle as issue
    exp_q.push_back('{op: 4'd3, a: 32'd55, b: 32'd9});
    cdb_valid_i = 1'b1; cdb_tag_i = 3'd4; cdb_data_i = 32'd55;
    issue(4'd3, 1'b0, 3'd4, 32'd0, 1'b1, 3'd0, 32'd9);
    cdb_valid_i = 1'b0;
    chk(fu_valid_o == 1'b1 && fu_src0_o == 32'd55, "R8 same-cycle capture", {32'h0, fu_src0_o}, 64'd55);
    accept();

    // both sources on one tag
    exp_q.push_back('{op: 4'd4, a: 32'd66, b: 32'd66});
    issue(4'd4, 1'b0, 3'd1, 32'd0, 1'b0, 3'd1, 32'd0);
    chk(fu_valid_o == 1'b0, "R4 both waiting", {63'h0, fu_valid_o}, 64'h0);
    bcast(3'd1, 32'd66);
    chk(fu_valid_o == 1'b1 && fu_src0_o == 32'd66 && fu_src1_o == 32'd66, "R11 shared tag fill",
        {fu_src0_o, fu_src1_o}, {32'd66, 32'd66});
    accept();

    // flush beats a simultaneous issue
    issue(4'd5, 1'b0, 3'd6, 32'd0, 1'b1, 3'd0, 32'd1);
    flush_i = 1'b1;
    issue(4'd6, 1'b1, 3'd0, 32'd1, 1'b1, 3'd0, 32'd2);
    flush_i = 1'b0;
    chk(busy_o == 1'b0, "R10 flush frees", {63'h0, busy_o}, 64'h0);
    bcast(3'd6, 32'd1);
    chk(busy_o == 1'b0 && fu_valid_o == 1'b0, "R10 dropped instruction silent", {63'h0, fu_valid_o}, 64'h0);

    // accept ready already high at issue
    fu_ready_i = 1'b1;
    exp_q.push_back('{op: 4'd8, a: 32'd3, b: 32'd4});
    issue(4'd8, 1'b1, 3'd0, 32'd3, 1'b1, 3'd0, 32'd4);
    chk(fu_valid_o == 1'b1, "R4 immediate offer", {63'h0, fu_valid_o}, 64'h1);
    step();
    fu_ready_i = 1'b0;
    chk(busy_o == 1'b0, "R9 free after immediate accept", {63'h0, busy_o}, 64'h0);

    step();
    chk(exp_q.size() == 0, "R4 all dispatches seen", 64'(exp_q.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule